// File: doc/BRIEF.md
# Receive Frame Queue with Overflow Policy

This block sits on the receive side of a serial port. Each time a frame has been fully shifted in, a one-cycle strobe hands the frame word to the block. The block stores frames in a small first-in first-out ring. A host or DMA engine takes them out through a read port. The head entry is always shown on the read data output, and a pop strobe removes it. The output level reports how many entries the ring holds.

A single holding stage stands in for the receive shift register. It catches one frame when the ring is full. That frame moves into the ring as soon as a pop frees a slot. If another frame completes while both the ring and the holding stage are occupied, this is an overflow. A sticky flag records it. A mode input then selects one of two behaviours: the new frame is dropped, or it replaces the frame waiting in the holding stage.

A second sticky flag asks software or DMA to drain the ring. It is raised whenever entries are present. It is lowered only after the ring has emptied, and then only by a DMA read-done strobe or by a write-one-to-clear from software.

Top module: `rx_frame_queue`

## Requirements
- R1: A frame completion while the ring has a free slot and the holding stage is empty appends the frame to the ring. The level rises by one on the next cycle.
- R2: A frame completion while the ring is full and the holding stage is empty parks the frame in the holding stage. The level stays at DEPTH. The next accepted pop moves the parked frame into the ring behind the existing entries, and the level stays at DEPTH in that cycle.
- R3: A frame completion with the ring full, the holding stage occupied and no pop in the same cycle sets the overflow flag on the next cycle.
- R4: With the overflow mode input at 1, the overflowing frame replaces the contents of the holding stage. That newer frame is the one that later reaches the ring.
- R5: With the overflow mode input at 0, the overflowing frame is dropped. The holding stage keeps its earlier frame.
- R6: The read data output always shows the oldest stored entry. A pop with at least one entry removes that entry and lowers the level by one, unless a frame enters the ring in the same cycle.
- R7: A pop while the level is 0 is ignored, and the level stays 0.
- R8: The drain flag is 1 in every cycle in which the level is non-zero.
- R9: Once the level is 0, the drain flag clears on a DMA read-done strobe or on a drain-clear write. Either strobe has no effect while the level is non-zero.
- R10: The overflow flag stays set until an overflow-clear write. A set condition in the same cycle as a clear write leaves the flag set.
- R11: A frame completion and an accepted pop in the same cycle leave the level unchanged and keep arrival order.
- R12: While reset is asserted, the level is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_done | input | 1 | One-cycle strobe: a received frame is complete |
| frm_data | input | DATA_W | Received frame word, valid with frm_done |
| pop_req | input | 1 | One-cycle strobe: remove the head entry |
| pop_data | output | DATA_W | Head entry of the ring (don't-care when empty) |
| dma_rd_done | input | 1 | DMA strobe: a read through the pop port is complete |
| ovwr_mode | input | 1 | Overflow mode: 1 replaces the held frame, 0 drops the new frame |
| ovf_clr_w1 | input | 1 | Software write-one strobe clearing the overflow flag |
| drain_clr_w1 | input | 1 | Software write-one strobe clearing the drain flag |
| fill_level | output | $clog2(DEPTH+1) | Number of entries in the ring |
| ovf_flag | output | 1 | Sticky overflow flag |
| drain_flag | output | 1 | Drain-request flag |

## Verification
The properties assume that every strobe lasts one cycle and is sampled only outside reset. They also assume that a pop is counted only when entries exist, so the level checks name the frame strobe and the holding-stage state explicitly instead of presuming the inputs are quiet. The stimulus changes inputs only at falling edges. It drives at most one frame per cycle, and it checks the head word before the edge that consumes it. Same-cycle combinations (pop with frame, clear with set, DMA strobe with a non-empty ring) are given their own vectors, so that no property depends on those inputs being mutually exclusive.

// File: rtl/rfq_pkg.sv
package rfq_pkg;

   typedef enum logic {
      POL_DISCARD = 1'b0,
      POL_REPLACE = 1'b1
   } ovf_pol_e;

   function automatic int unsigned lvl_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/rfq_ring.sv
module rfq_ring #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic                            rd_en,
   output logic [DATA_W-1:0]               rd_data,
   output logic [$clog2(DEPTH+1)-1:0]      level,
   output logic                            full,
   output logic                            empty
);
   localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CNT_W = $clog2(DEPTH + 1);
   localparam bit  POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr_inc, rd_ptr_inc;
   logic [CNT_W-1:0]  level_q;

   generate
      if (POW2) begin : g_pow2_wrap
         assign wr_ptr_inc = wr_ptr + 1'b1;
         assign rd_ptr_inc = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_ptr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_ptr_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_ptr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else begin
         if (wr_en) begin
            wr_ptr <= wr_ptr_inc;
         end
         if (rd_en) begin
            rd_ptr <= rd_ptr_inc;
         end
         case ({wr_en, rd_en})
            2'b10:   level_q <= level_q + CNT_W'(1);
            2'b01:   level_q <= level_q - CNT_W'(1);
            default: level_q <= level_q;
         endcase
      end
   end

   assign rd_data = mem[rd_ptr];
   assign level   = level_q;
   assign full    = (level_q == CNT_W'(DEPTH));
   assign empty   = (level_q == '0);

endmodule

// File: rtl/rfq_stage.sv
module rfq_stage #(
   parameter int DATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frm_done,
   input  logic [DATA_W-1:0]      frm_data,
   input  logic                   ring_full,
   input  logic                   pop_ok,
   input  rfq_pkg::ovf_pol_e      policy,
   output logic                   push,
   output logic [DATA_W-1:0]      push_data,
   output logic                   ovf_evt,
   output logic                   hold_valid
);
   logic              hold_v_q, hold_v_d;
   logic [DATA_W-1:0] hold_q, hold_d;

   always_comb begin
      push      = 1'b0;
      push_data = frm_data;
      ovf_evt   = 1'b0;
      hold_v_d  = hold_v_q;
      hold_d    = hold_q;
      if (hold_v_q) begin
         if (pop_ok) begin
            push      = 1'b1;
            push_data = hold_q;
            if (frm_done) begin
               hold_d = frm_data;
            end else begin
               hold_v_d = 1'b0;
            end
         end else if (frm_done) begin
            ovf_evt = 1'b1;
            if (policy == rfq_pkg::POL_REPLACE) begin
               hold_d = frm_data;
            end
         end
      end else if (frm_done) begin
         if (!ring_full || pop_ok) begin
            push = 1'b1;
         end else begin
            hold_v_d = 1'b1;
            hold_d   = frm_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v_q <= 1'b0;
         hold_q   <= '0;
      end else begin
         hold_v_q <= hold_v_d;
         hold_q   <= hold_d;
      end
   end

   assign hold_valid = hold_v_q;

endmodule

// File: rtl/rfq_flags.sv
module rfq_flags #(
   parameter int DEPTH = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [$clog2(DEPTH+1)-1:0]    level,
   input  logic                          push,
   input  logic                          pop_ok,
   input  logic                          ovf_evt,
   input  logic                          ovf_clr,
   input  logic                          dma_done,
   input  logic                          drain_clr,
   output logic                          ovf_flag,
   output logic                          drain_flag
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic ovf_q, ovf_d, drain_q, drain_d, nonempty_nxt;

   always_comb begin
      nonempty_nxt = push || (level > CNT_W'(1)) || ((level == CNT_W'(1)) && !pop_ok);
      drain_d = drain_q;
      if (nonempty_nxt) begin
         drain_d = 1'b1;
      end else if (dma_done || drain_clr) begin
         drain_d = 1'b0;
      end
      ovf_d = ovf_q;
      if (ovf_evt) begin
         ovf_d = 1'b1;
      end else if (ovf_clr) begin
         ovf_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q   <= 1'b0;
         drain_q <= 1'b0;
      end else begin
         ovf_q   <= ovf_d;
         drain_q <= drain_d;
      end
   end

   assign ovf_flag   = ovf_q;
   assign drain_flag = drain_q;

endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_done,
   input  logic [DATA_W-1:0] frm_data,
   input  logic              pop_req,
   output logic [DATA_W-1:0] pop_data,
   input  logic              dma_rd_done,
   input  logic              ovwr_mode,
   input  logic              ovf_clr_w1,
   input  logic              drain_clr_w1,
   output logic [CNT_W-1:0]  fill_level,
   output logic              ovf_flag,
   output logic              drain_flag
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_frame_queue: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_frame_queue: DATA_W must be at least 1");
      end
      if (CNT_W != rfq_pkg::lvl_width(DEPTH)) begin : g_bad_cnt
         $error("rx_frame_queue: level width mismatch");
      end
   endgenerate

   logic              ring_full, ring_empty, pop_ok;
   logic              push;
   logic [DATA_W-1:0] push_data;
   logic              ovf_evt;
   logic              hold_valid;
   logic [CNT_W-1:0]  level;

   assign pop_ok = pop_req && !ring_empty;

   rfq_ring #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) ring_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push),
      .wr_data (push_data),
      .rd_en   (pop_ok),
      .rd_data (pop_data),
      .level   (level),
      .full    (ring_full),
      .empty   (ring_empty)
   );

   rfq_stage #(
      .DATA_W (DATA_W)
   ) stage_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .frm_done   (frm_done),
      .frm_data   (frm_data),
      .ring_full  (ring_full),
      .pop_ok     (pop_ok),
      .policy     (rfq_pkg::ovf_pol_e'(ovwr_mode)),
      .push       (push),
      .push_data  (push_data),
      .ovf_evt    (ovf_evt),
      .hold_valid (hold_valid)
   );

   rfq_flags #(
      .DEPTH (DEPTH)
   ) flags_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .level      (level),
      .push       (push),
      .pop_ok     (pop_ok),
      .ovf_evt    (ovf_evt),
      .ovf_clr    (ovf_clr_w1),
      .dma_done   (dma_rd_done),
      .drain_clr  (drain_clr_w1),
      .ovf_flag   (ovf_flag),
      .drain_flag (drain_flag)
   );

   assign fill_level = level;

endmodule

// File: rtl/rfq_chk.sv
module rfq_chk #(
   parameter int DEPTH = 4,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frm_done,
   input logic             pop_req,
   input logic             ovf_clr_w1,
   input logic             hold_v,
   input logic [CNT_W-1:0] fill_level,
   input logic             ovf_flag,
   input logic             drain_flag
);
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level <= CNT_W'(DEPTH));                                         // R1

   AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      hold_v |-> fill_level == CNT_W'(DEPTH));                              // R2

   AST_OVF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && hold_v && !pop_req) |=> ovf_flag);                       // R3

   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && fill_level != '0 && !frm_done && !hold_v)
      |=> fill_level == CNT_W'($past(fill_level) - CNT_W'(1)));             // R6

   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && fill_level == '0 && !frm_done) |=> fill_level == '0);     // R7

   AST_DRAIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level != '0 |-> drain_flag);                                     // R8

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr_w1) |=> ovf_flag);                              // R10

endmodule

bind rx_frame_queue rfq_chk #(
   .DEPTH (DEPTH),
   .CNT_W (CNT_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .frm_done   (frm_done),
   .pop_req    (pop_req),
   .ovf_clr_w1 (ovf_clr_w1),
   .hold_v     (hold_valid),
   .fill_level (fill_level),
   .ovf_flag   (ovf_flag),
   .drain_flag (drain_flag)
);

// File: tb/rx_frame_queue_tb_top.sv
`timescale 1ns/1ps
module rx_frame_queue_tb_top;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 4;
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int NV     = 43;

   typedef struct packed {
      logic              fd;
      logic [DATA_W-1:0] dat;
      logic              pop;
      logic              dma;
      logic              pol;
      logic              co;
      logic              cd;
      logic              hchk;
      logic [DATA_W-1:0] head;
      logic [CNT_W-1:0]  cnt;
      logic              ovf;
      logic              drn;
      logic [7:0]        req;
   } vec_t;

   // fields: fd dat pop dma pol co cd hchk head cnt ovf drn req
   localparam vec_t VEC [NV] = '{
      '{1'b1,16'hA001,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd1,1'b0,1'b1,8'd1},  // R1 R8
      '{1'b1,16'hA002,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd2,1'b0,1'b1,8'd1},
      '{1'b1,16'hA003,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd3,1'b0,1'b1,8'd1},
      '{1'b1,16'hA004,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd4,1'b0,1'b1,8'd1},
      '{1'b1,16'hA005,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd4,1'b0,1'b1,8'd2},  // R2 parked
      '{1'b1,16'hA006,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd4,1'b1,1'b1,8'd3},  // R3 overflow, drop
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hA001,3'd4,1'b1,1'b1,8'd2},  // R2 parked moves in
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hA002,3'd3,1'b1,1'b1,8'd6},  // R6
      '{1'b0,16'h0000,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,16'hA003,3'd2,1'b1,1'b1,8'd9},  // R9 dma while non-empty
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hA004,3'd1,1'b1,1'b1,8'd6},
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hA005,3'd0,1'b1,1'b1,8'd5},  // R5 A006 dropped
      '{1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,3'd0,1'b0,1'b1,8'd10}, // R10 clear
      '{1'b0,16'h0000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd0,1'b0,1'b0,8'd9},  // R9 dma clears
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd0,1'b0,1'b0,8'd7},  // R7 empty pop
      '{1'b1,16'hB001,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,3'd1,1'b0,1'b1,8'd1},
      '{1'b1,16'hB002,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,3'd2,1'b0,1'b1,8'd1},
      '{1'b1,16'hB003,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,3'd3,1'b0,1'b1,8'd1},
      '{1'b1,16'hB004,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,3'd4,1'b0,1'b1,8'd1},
      '{1'b1,16'hB005,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,3'd4,1'b0,1'b1,8'd2},
      '{1'b1,16'hB006,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,3'd4,1'b1,1'b1,8'd4},  // R4 replace
      '{1'b1,16'hB007,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,16'h0000,3'd4,1'b1,1'b1,8'd10}, // R10 set beats clear
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hB001,3'd4,1'b1,1'b1,8'd6},
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hB002,3'd3,1'b1,1'b1,8'd6},
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hB003,3'd2,1'b1,1'b1,8'd6},
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hB004,3'd1,1'b1,1'b1,8'd6},
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hB007,3'd0,1'b1,1'b1,8'd4},  // R4 newest kept
      '{1'b1,16'hC001,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,3'd1,1'b0,1'b1,8'd10},
      '{1'b1,16'hC002,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,16'hC001,3'd1,1'b0,1'b1,8'd11}, // R11, R9 clear ignored
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hC002,3'd0,1'b0,1'b1,8'd11},
      '{1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,3'd0,1'b0,1'b0,8'd9},  // R9 write clears
      '{1'b1,16'hD001,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd1,1'b0,1'b1,8'd1},
      '{1'b1,16'hD002,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd2,1'b0,1'b1,8'd1},
      '{1'b1,16'hD003,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd3,1'b0,1'b1,8'd1},
      '{1'b1,16'hD004,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd4,1'b0,1'b1,8'd1},
      '{1'b1,16'hD005,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd4,1'b0,1'b1,8'd2},
      '{1'b1,16'hD006,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hD001,3'd4,1'b0,1'b1,8'd11}, // R11 full + parked
      '{1'b1,16'hD007,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,3'd4,1'b1,1'b1,8'd3},
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hD002,3'd4,1'b1,1'b1,8'd2},
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hD003,3'd3,1'b1,1'b1,8'd6},
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hD004,3'd2,1'b1,1'b1,8'd6},
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hD005,3'd1,1'b1,1'b1,8'd11},
      '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'hD006,3'd0,1'b1,1'b1,8'd5},
      '{1'b0,16'h0000,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,3'd0,1'b0,1'b0,8'd9}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              frm_done, pop_req, dma_rd_done, ovwr_mode, ovf_clr_w1, drain_clr_w1;
   logic [DATA_W-1:0] frm_data;
   logic [DATA_W-1:0] pop_data;
   logic [CNT_W-1:0]  fill_level;
   logic              ovf_flag, drain_flag;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   rx_frame_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .frm_done     (frm_done),
      .frm_data     (frm_data),
      .pop_req      (pop_req),
      .pop_data     (pop_data),
      .dma_rd_done  (dma_rd_done),
      .ovwr_mode    (ovwr_mode),
      .ovf_clr_w1   (ovf_clr_w1),
      .drain_clr_w1 (drain_clr_w1),
      .fill_level   (fill_level),
      .ovf_flag     (ovf_flag),
      .drain_flag   (drain_flag)
   );

   task automatic check(input int act, input int exp, input string req, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      frm_done = 1'b0; frm_data = '0; pop_req = 1'b0; dma_rd_done = 1'b0;
      ovwr_mode = 1'b0; ovf_clr_w1 = 1'b0; drain_clr_w1 = 1'b0;
   endtask

   task automatic check_state(input int c, input int o, input int d, input string req);
      check(int'(fill_level), c, req, "level");
      check(int'(ovf_flag),   o, req, "overflow flag");
      check(int'(drain_flag), d, req, "drain flag");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_state(0, 0, 0, "R12");
      rst_n = 1'b1;
      @(negedge clk);
      check_state(0, 0, 0, "R12");

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d", VEC[i].req);
         frm_done     = VEC[i].fd;
         frm_data     = VEC[i].dat;
         pop_req      = VEC[i].pop;
         dma_rd_done  = VEC[i].dma;
         ovwr_mode    = VEC[i].pol;
         ovf_clr_w1   = VEC[i].co;
         drain_clr_w1 = VEC[i].cd;
         #1;
         if (VEC[i].hchk) begin
            check(int'(pop_data), int'(VEC[i].head), tag, $sformatf("head at vector %0d", i));
         end
         @(posedge clk);
         @(negedge clk);
         idle();
         check_state(int'(VEC[i].cnt), int'(VEC[i].ovf), int'(VEC[i].drn), tag);
      end

      // R12: reset in the middle of traffic returns everything to zero
      for (int k = 0; k < 5; k++) begin
         frm_done = 1'b1;
         frm_data = DATA_W'(16'hE000 + k);
         @(negedge clk);
      end
      frm_done = 1'b1;
      frm_data = 16'hEEEE;
      @(negedge clk);
      idle();
      check_state(4, 1, 1, "R3");
      rst_n = 1'b0;
      @(negedge clk);
      check_state(0, 0, 0, "R12");
      rst_n = 1'b1;
      @(negedge clk);
      pop_req = 1'b1;
      @(negedge clk);
      idle();
      check_state(0, 0, 0, "R7");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule